// File: doc/BRIEF.md
# Multiplexed LCD Segment Scanner with Blink

This block keeps the segment memory of a multiplexed liquid-crystal panel driven by two, three or four backplanes and up to 41 frontplanes. On every frame tick from an external timebase it steps to the next backplane phase. It then presents the index of that backplane together with one lit/unlit bit for each frontplane. An analog output stage outside this block turns these into drive voltages.

Software reaches both segment planes through one byte-wide window. A plane-select input decides whether that window addresses the display plane, which holds each segment's on/off state, or the blink plane, which marks the segments allowed to blink. A blink timebase toggles a blink phase. In the off half of that phase, marked segments go dark. A blink-all input applies the same darkening to every segment. The blink phase depends only on its own tick and enable, so blinking keeps running while the panel is disabled or the register port is idle.

Top module: `lcd_seg_scan`

## Requirements
- R1: After reset, `bp_idx` is 0, `fp_out` is all zero and `reg_rdata` is 0. Both planes are cleared and four backplanes are active.
- R2: Byte address n holds two frontplanes. Bits [3:0] belong to frontplane 2n and bits [7:4] to frontplane 2n+1. Within each nibble, bit i is the segment for backplane i. A read pulse at a clock edge loads `reg_rdata` at that edge. `reg_rdata` then holds its value until the next read pulse.
- R3: Address 20 carries only frontplane 40, and its bits [7:4] always read 0. Addresses 21 to 31 read 0, and writes to them change neither plane.
- R4: With `plane_sel`=0, reads and writes go to the display plane. With `plane_sel`=1, the same addresses go to the blink plane. A write to one plane leaves the other plane unchanged.
- R5: `duty_sel` gives the number of backplanes minus one: 1 selects two, 2 selects three, 3 selects four, and 0 is treated as 1. While enabled, `bp_idx` moves up by one at each clock edge where `frame_tick` is high. After the last active backplane it wraps to 0. Without a tick, `bp_idx` holds.
- R6: A change of `duty_sel` while enabled takes effect only when `bp_idx` wraps to 0.
- R7: With blinking inactive, `fp_out[f]` equals the display-plane bit of frontplane f for backplane `bp_idx`.
- R8: Each clock edge with `blink_tick` and `blink_en` both high toggles the blink phase, which starts in its on half. While `blink_en` is low, the phase is forced back to the on half. In the off half, a segment whose blink-plane bit is 1 drives 0.
- R9: With `blink_all`=1, every segment drives 0 during the off half, whatever the blink plane holds.
- R10: While `lcd_en` is low, `fp_out` is all zero. From the next clock edge, `bp_idx` is 0 and the active duty is reloaded from `duty_sel`.
- R11: While four backplanes are active, `fp_out[40]` is 0 because its pin serves as the fourth backplane. With two or three backplanes, it follows the display plane like any other frontplane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the byte window |
| reg_rd | input | 1 | Read strobe for the byte window |
| reg_addr | input | 5 | Byte address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, loaded one edge after the strobe |
| plane_sel | input | 1 | 0 selects the display plane, 1 selects the blink plane |
| duty_sel | input | 2 | Backplane count minus one |
| lcd_en | input | 1 | Panel enable |
| frame_tick | input | 1 | Advance to the next backplane phase |
| blink_en | input | 1 | Enable blinking |
| blink_tick | input | 1 | Toggle the blink phase |
| blink_all | input | 1 | Blink every segment |
| bp_idx | output | 2 | Active backplane index |
| fp_out | output | 41 | Lit/unlit bit per frontplane for the active backplane |

## Verification
A wrong backplane counter shows on the first frame tick that follows the error. `bp_idx` takes a value outside the active duty, or it wraps early or late, and `fp_out` shows the nibble column for the wrong backplane. A duty value reloaded at the wrong time shifts the wrap point of the very next frame. Corrupted plane storage appears either on the read one edge after a strobe or in `fp_out` once the affected backplane becomes active. A blink phase stuck in the wrong half inverts the masking of every marked segment on every backplane until the next blink tick.

// File: rtl/lcd_seg_pkg.sv
`timescale 1ns/1ps
package lcd_seg_pkg;
  localparam int unsigned LCD_NUM_BP = 4;
  localparam int unsigned LCD_BP_W   = 2;

  typedef logic [LCD_BP_W-1:0] bp_idx_t;

  // Last active backplane index selected by the duty field (0 behaves as 1).
  function automatic bp_idx_t duty_last(input logic [1:0] sel);
    return (sel == 2'd0) ? bp_idx_t'(1) : bp_idx_t'(sel);
  endfunction
endpackage

// File: rtl/lcd_seg_plane.sv
`timescale 1ns/1ps
module lcd_seg_plane #(
  parameter int NUM_FP = 41,
  parameter int ADDR_W = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [7:0]            wr_data,
  input  logic [ADDR_W-1:0]     rd_addr,
  output logic [7:0]            rd_byte,
  output logic [NUM_FP*4-1:0]   segs
);
  logic [NUM_FP*4-1:0] seg_q, seg_d;

  // Next state: each frontplane nibble loads from its half of the write byte.
  always_comb begin
    seg_d = seg_q;
    for (int f = 0; f < NUM_FP; f++) begin
      if (wr_addr == ADDR_W'(f / 2)) begin
        seg_d[4*f +: 4] = wr_data[4*(f % 2) +: 4];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q <= '0;
    end else if (wr_en) begin
      seg_q <= seg_d;
    end
  end

  // Read byte: unmapped nibbles and addresses return zero.
  always_comb begin
    rd_byte = '0;
    for (int f = 0; f < NUM_FP; f++) begin
      if (rd_addr == ADDR_W'(f / 2)) begin
        rd_byte[4*(f % 2) +: 4] = seg_q[4*f +: 4];
      end
    end
  end

  assign segs = seg_q;
endmodule

// File: rtl/lcd_bp_seq.sv
`timescale 1ns/1ps
module lcd_bp_seq
  import lcd_seg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       frame_tick,
  input  logic [1:0] duty_sel,
  output bp_idx_t    bp_idx,
  output bp_idx_t    last_idx
);
  bp_idx_t bp_q, bp_d, last_q, last_d;
  logic    upd;

  always_comb begin
    bp_d   = bp_q;
    last_d = last_q;
    upd    = 1'b0;
    if (!enable) begin
      bp_d   = '0;
      last_d = duty_last(duty_sel);
      upd    = 1'b1;
    end else if (frame_tick) begin
      upd = 1'b1;
      if (bp_q >= last_q) begin
        bp_d   = '0;
        last_d = duty_last(duty_sel);
      end else begin
        bp_d = bp_q + bp_idx_t'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bp_q   <= '0;
      last_q <= bp_idx_t'(LCD_NUM_BP - 1);
    end else if (upd) begin
      bp_q   <= bp_d;
      last_q <= last_d;
    end
  end

  assign bp_idx   = bp_q;
  assign last_idx = last_q;
endmodule

// File: rtl/lcd_blink_phase.sv
`timescale 1ns/1ps
module lcd_blink_phase (
  input  logic clk,
  input  logic rst_n,
  input  logic blink_en,
  input  logic blink_tick,
  output logic off_half
);
  logic ph_q, ph_d, upd;

  always_comb begin
    upd  = !blink_en || blink_tick;
    ph_d = blink_en ? !ph_q : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= 1'b0;
    end else if (upd) begin
      ph_q <= ph_d;
    end
  end

  assign off_half = ph_q;
endmodule

// File: rtl/lcd_seg_scan.sv
`timescale 1ns/1ps
module lcd_seg_scan
  import lcd_seg_pkg::*;
#(
  parameter int NUM_FP    = 41,
  parameter int ADDR_W    = 5,
  parameter bit SHARED_FP = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              plane_sel,
  input  logic [1:0]        duty_sel,
  input  logic              lcd_en,
  input  logic              frame_tick,
  input  logic              blink_en,
  input  logic              blink_tick,
  input  logic              blink_all,
  output logic [1:0]        bp_idx,
  output logic [NUM_FP-1:0] fp_out
);
  localparam int NUM_PLANES = 2;
  localparam int SEG_W      = NUM_FP * 4;

  logic [SEG_W-1:0] plane_segs [NUM_PLANES];
  logic [7:0]       plane_byte [NUM_PLANES];
  logic [7:0]       rdata_q, rdata_d;
  bp_idx_t          bp_cur, last_idx;
  logic             blink_off;

  // Plane 0 holds the display bits, plane 1 the blink-enable bits.
  for (genvar p = 0; p < NUM_PLANES; p++) begin : g_plane
    lcd_seg_plane #(.NUM_FP(NUM_FP), .ADDR_W(ADDR_W)) u_plane (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (reg_wr && (plane_sel == 1'(p))),
      .wr_addr (reg_addr),
      .wr_data (reg_wdata),
      .rd_addr (reg_addr),
      .rd_byte (plane_byte[p]),
      .segs    (plane_segs[p])
    );
  end

  lcd_bp_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (lcd_en),
    .frame_tick (frame_tick),
    .duty_sel   (duty_sel),
    .bp_idx     (bp_cur),
    .last_idx   (last_idx)
  );

  lcd_blink_phase u_blink (
    .clk        (clk),
    .rst_n      (rst_n),
    .blink_en   (blink_en),
    .blink_tick (blink_tick),
    .off_half   (blink_off)
  );

  // Read-data register with a written-out enable.
  always_comb begin
    rdata_d = plane_sel ? plane_byte[1] : plane_byte[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (reg_rd) begin
      rdata_q <= rdata_d;
    end
  end

  // Frontplane column for the active backplane, with blink masking.
  always_comb begin
    for (int f = 0; f < NUM_FP; f++) begin
      logic dsp, blk;
      dsp = plane_segs[0][4*f + int'(bp_cur)];
      blk = plane_segs[1][4*f + int'(bp_cur)];
      fp_out[f] = lcd_en && dsp && !(blink_off && (blk || blink_all));
    end
    if (SHARED_FP && (last_idx == bp_idx_t'(LCD_NUM_BP - 1))) begin
      fp_out[NUM_FP-1] = 1'b0;
    end
  end

  assign reg_rdata = rdata_q;
  assign bp_idx    = bp_cur;
endmodule

// File: rtl/lcd_seg_scan_chk.sv
`timescale 1ns/1ps
module lcd_seg_scan_chk #(
  parameter int NUM_FP = 41,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [7:0]        reg_rdata,
  input logic              lcd_en,
  input logic              frame_tick,
  input logic              blink_all,
  input logic              blink_off,
  input logic [1:0]        bp_idx,
  input logic [NUM_FP-1:0] fp_out
);
  a_r10_dark_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !lcd_en |-> fp_out == '0);

  a_r10_phase_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !lcd_en |=> bp_idx == 2'd0);

  a_r5_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (lcd_en && !frame_tick) |=> bp_idx == $past(bp_idx));

  a_r11_shared_pin: assert property (@(posedge clk) disable iff (!rst_n)
    bp_idx == 2'd3 |-> !fp_out[NUM_FP-1]);

  a_r3_top_nibble_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == ADDR_W'(20)) |=> reg_rdata[7:4] == 4'h0);

  a_r2_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> $stable(reg_rdata));

  a_r9_blink_all_dark: assert property (@(posedge clk) disable iff (!rst_n)
    (blink_all && blink_off) |-> fp_out == '0);
endmodule

bind lcd_seg_scan lcd_seg_scan_chk #(.NUM_FP(NUM_FP), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_rd     (reg_rd),
  .reg_addr   (reg_addr),
  .reg_rdata  (reg_rdata),
  .lcd_en     (lcd_en),
  .frame_tick (frame_tick),
  .blink_all  (blink_all),
  .blink_off  (blink_off),
  .bp_idx     (bp_idx),
  .fp_out     (fp_out)
);

// File: tb/lcd_seg_scan_test.sv
`timescale 1ns/1ps
module lcd_seg_scan_test;
  localparam int NFP = 41;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic plane_sel = 1'b0;
  logic [1:0] duty_sel = 2'd3;
  logic lcd_en = 1'b0, frame_tick = 1'b0;
  logic blink_en = 1'b0, blink_tick = 1'b0, blink_all = 1'b0;
  logic [1:0] bp_idx;
  logic [NFP-1:0] fp_out;

  int n_chk = 0, n_bad = 0;
  logic [3:0] m_dsp [NFP];
  logic [3:0] m_blk [NFP];
  int m_bp = 0, m_last = 3;
  logic m_phase = 1'b0;
  bit done = 0;

  always #5 clk = ~clk;

  lcd_seg_scan uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .plane_sel(plane_sel), .duty_sel(duty_sel), .lcd_en(lcd_en),
    .frame_tick(frame_tick), .blink_en(blink_en), .blink_tick(blink_tick),
    .blink_all(blink_all), .bp_idx(bp_idx), .fp_out(fp_out)
  );

  function automatic int dlast(input logic [1:0] s);
    return (s == 2'd0) ? 1 : int'(s);
  endfunction

  function automatic logic [7:0] pat(input int n);
    return 8'(n * 53 + 29) ^ 8'hA5;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [NFP-1:0] exp_fp();
    logic [NFP-1:0] v;
    for (int f = 0; f < NFP; f++) begin
      logic d, m;
      d = m_dsp[f][m_bp];
      m = m_phase && (m_blk[f][m_bp] || blink_all);
      v[f] = lcd_en && d && !m;
    end
    if (m_last == 3) v[NFP-1] = 1'b0;
    return v;
  endfunction

  task automatic check_out(input string tag);
    check({tag, " bp_idx"}, 64'(bp_idx), 64'(m_bp));
    check({tag, " fp_out"}, 64'(fp_out), 64'(exp_fp()));
  endtask

  task automatic wr(input logic pl, input int a, input logic [7:0] d);
    @(negedge clk);
    plane_sel = pl; reg_addr = 5'(a); reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    if (a < 21) begin
      for (int k = 0; k < 2; k++) begin
        int f;
        f = 2 * a + k;
        if (f < NFP) begin
          if (pl) m_blk[f] = d[4*k +: 4];
          else    m_dsp[f] = d[4*k +: 4];
        end
      end
    end
  endtask

  function automatic logic [7:0] exp_byte(input logic pl, input int a);
    logic [7:0] v;
    v = '0;
    if (a < 21) begin
      for (int k = 0; k < 2; k++) begin
        int f;
        f = 2 * a + k;
        if (f < NFP) v[4*k +: 4] = pl ? m_blk[f] : m_dsp[f];
      end
    end
    return v;
  endfunction

  task automatic rd_check(input logic pl, input int a, input string tag);
    @(negedge clk);
    plane_sel = pl; reg_addr = 5'(a); reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    check(tag, 64'(reg_rdata), 64'(exp_byte(pl, a)));
  endtask

  task automatic step_frame();
    @(negedge clk); frame_tick = 1'b1;
    @(negedge clk); frame_tick = 1'b0;
    if (lcd_en) begin
      if (m_bp >= m_last) begin m_bp = 0; m_last = dlast(duty_sel); end
      else m_bp++;
    end
  endtask

  task automatic step_blink();
    @(negedge clk); blink_tick = 1'b1;
    @(negedge clk); blink_tick = 1'b0;
    if (blink_en) m_phase = !m_phase;
  endtask

  task automatic set_en(input logic v);
    @(negedge clk); lcd_en = v;
    @(negedge clk);
    if (!v) begin m_bp = 0; m_last = dlast(duty_sel); end
  endtask

  // R1
  task automatic t_reset();
    check("R1 bp_idx", 64'(bp_idx), 64'd0);
    check("R1 fp_out", 64'(fp_out), 64'd0);
    check("R1 reg_rdata", 64'(reg_rdata), 64'd0);
  endtask

  // R2, R7: byte packing, read latency, column output
  task automatic t_display_fill();
    for (int a = 0; a < 21; a++) wr(1'b0, a, pat(a));
    for (int a = 0; a < 21; a += 4) rd_check(1'b0, a, "R2 display readback");
    @(negedge clk); plane_sel = 1'b0; reg_addr = 5'd3; reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0; reg_addr = 5'd7;
    @(negedge clk);
    check("R2 rdata holds without read", 64'(reg_rdata), 64'(exp_byte(1'b0, 3)));
    set_en(1'b1);
    check_out("R7 column bp0");
  endtask

  // R4: plane select routing
  task automatic t_planes();
    for (int a = 0; a < 21; a++) wr(1'b1, a, 8'(a * 17) ^ 8'h3C);
    rd_check(1'b1, 5, "R4 blink plane readback");
    rd_check(1'b0, 5, "R4 display plane untouched");
    rd_check(1'b1, 12, "R4 blink plane readback");
    check_out("R4 blink bits do not mask when blink off");
  endtask

  // R3: top byte and out-of-range addresses
  task automatic t_top_range();
    wr(1'b0, 20, 8'hFF);
    rd_check(1'b0, 20, "R3 byte 20 upper nibble zero");
    wr(1'b0, 25, 8'hFF);
    wr(1'b1, 31, 8'hFF);
    rd_check(1'b0, 25, "R3 out of range reads zero");
    rd_check(1'b0, 0, "R3 out of range write ignored");
    rd_check(1'b1, 20, "R3 blink plane unaffected");
    check_out("R3 outputs after ignored write");
  endtask

  // R5, R7, R11: four-backplane scan
  task automatic t_scan4();
    for (int i = 0; i < 5; i++) begin
      step_frame();
      check_out("R5 R11 four backplane scan");
    end
    @(negedge clk); @(negedge clk);
    check_out("R5 hold without tick");
  endtask

  // R6, R11: duty change waits for wrap
  task automatic t_duty_change();
    duty_sel = 2'd2;
    for (int i = 0; i < 7; i++) begin
      step_frame();
      check_out("R6 duty change at wrap");
    end
    check("R11 fp40 driven in three backplane mode", 64'(m_last), 64'd2);
    duty_sel = 2'd0;
    for (int i = 0; i < 5; i++) begin
      step_frame();
      check_out("R5 R11 duty code 0 as two backplanes");
    end
  endtask

  // R8, R9: blink masking
  task automatic t_blink();
    blink_en = 1'b1;
    step_blink();
    for (int i = 0; i < 2; i++) begin
      check_out("R8 off half masks marked segments");
      step_frame();
    end
    blink_all = 1'b1;
    @(negedge clk);
    check_out("R9 blink all darkens every segment");
    step_blink();
    check_out("R9 on half shows display");
    blink_all = 1'b0;
    step_blink();
    set_en(1'b0);
    step_blink();
    set_en(1'b1);
    check_out("R8 phase toggles while panel disabled");
    step_blink();
    check_out("R8 off half after re-enable");
    @(negedge clk); blink_en = 1'b0;
    @(negedge clk); m_phase = 1'b0;
    check_out("R8 blink disable restores on half");
  endtask

  // R10
  task automatic t_disable();
    duty_sel = 2'd3;
    step_frame();
    @(negedge clk); lcd_en = 1'b0;
    #1;
    check("R10 fp_out dark at once", 64'(fp_out), 64'd0);
    @(negedge clk);
    m_bp = 0; m_last = 3;
    check_out("R10 phase reset while disabled");
    step_frame();
    check_out("R10 tick ignored while disabled");
    set_en(1'b1);
    for (int i = 0; i < 4; i++) begin
      step_frame();
      check_out("R10 R11 scan after re-enable");
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int f = 0; f < NFP; f++) begin m_dsp[f] = '0; m_blk[f] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_display_fill();
    t_planes();
    t_top_range();
    t_scan4();
    t_duty_change();
    t_blink();
    t_disable();
    finish_run();
  end
endmodule